// File: doc/BRIEF.md
# Storage Controller Power Mode Sequencer

This block holds the power state of a storage device controller and moves it between four states: `PM_IDLE`, `PM_ACTIVE`, `PM_SLEEP` and `PM_WAKE`. A new command or a soft reset wakes the controller or keeps it busy. When the work completes, the state falls back to idle on its own. If the controller stays idle for longer than a threshold that firmware can program, the block puts it to sleep and gates the main core clock. The block runs on an always-on clock, so it can still count and watch for wake events while the core clock is stopped.

The transitions have these names:
- **start**: an event moves idle to active.
- **finish**: `cmd_done` moves active to idle.
- **doze**: the inactivity timeout moves idle to sleep.
- **rouse**: an event moves sleep to wake.
- **settle**: after a fixed number of cycles, wake moves to active.
- **hw-reset**: a hardware reset moves any state to idle.

A command that arrives during sleep is not lost. The block holds it by entering the wake state, and it signals the first active cycle after the wake with a one-cycle `wake_o` pulse. The command logic then knows it must service the held request. The block does not contain the gating cell or the command decoder. It receives single-cycle pulses from the decoder and drives a clock-enable level.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `mode` is 0 (idle), `core_clk_en` is 1 and `wake_o` is 0.
- R2: In idle (`mode`=0), a `cmd_req` pulse or a `soft_rst` pulse makes `mode` equal 1 (active) after the next clock edge.
- R3: In active, `cmd_done` with no event in the same cycle makes `mode` 0 after the next edge. If `cmd_req` or `soft_rst` comes together with `cmd_done`, the state stays active. With neither pulse, the state stays active.
- R4: With `idle_limit`=L>0, an idle stretch without any event ends after exactly L cycles, and `mode` becomes 2 (sleep). The count restarts at zero every time idle is entered.
- R5: With `idle_limit`=0, the controller never leaves idle on its own.
- R6: `core_clk_en` is 0 in sleep and 1 in every other state.
- R7: In sleep, an event makes `mode` 3 (wake) with `core_clk_en` at 1. Wake lasts exactly SETTLE_CYC cycles, after which `mode` is 1.
- R8: `wake_o` is high for exactly one cycle: the first active cycle that follows wake. It is low at all other times.
- R9: In sleep, `cmd_done` has no effect and the state stays sleep. In wake, `cmd_req`, `soft_rst` and `cmd_done` have no effect, and the settle length does not change.
- R10: In idle, if an event arrives in the same cycle as the timeout expiry, the event wins and `mode` becomes 1, not 2.
- R11: A hardware reset that is applied in sleep or in wake returns `mode` to 0 and `core_clk_en` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cmd_req | input | 1 | Single-cycle pulse: a command has been received |
| soft_rst | input | 1 | Single-cycle pulse: a soft reset has been requested |
| cmd_done | input | 1 | Single-cycle pulse: the command or soft reset has finished |
| idle_limit | input | TW | Number of idle cycles before sleep; 0 disables sleep |
| mode | output | 2 | Current state: 0 idle, 1 active, 2 sleep, 3 wake |
| core_clk_en | output | 1 | Enable for the main core clock |
| wake_o | output | 1 | One-cycle pulse on the first active cycle after a wake |

## Verification
Two pairs of functions can fall in the same cycle:
- In idle, the inactivity timer can expire in the same cycle that a command or soft reset arrives. The bench provokes this by waiting L-1 quiet idle cycles and then driving `cmd_req` on the L-th cycle. It judges the result by checking that `mode` reads 1 and not 2.
- In active, a completion can coincide with a new event. Here the bench expects the state to stay active.

A random phase that is compared every clock against a behavioural model also produces both coincidences many times. In that phase the bench varies `idle_limit`, including zero.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        PM_IDLE   = 2'd0,
        PM_ACTIVE = 2'd1,
        PM_SLEEP  = 2'd2,
        PM_WAKE   = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pm_idle_timer.sv
// Inactivity counter. It counts while run is high and clears whenever run drops.
module pm_idle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Greater-or-equal, so that a threshold lowered below the running count still trips.
    always_comb begin
        expired = run && (limit != '0) && (cnt_q >= (limit - {{(TW-1){1'b0}}, 1'b1}));
    end
endmodule

// File: rtl/pm_settle_timer.sv
// Counts the settle cycles that follow a wake event.
module pm_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        done = run && (cnt_q == LAST);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode sequencer: idle / active / sleep / wake.
module pwr_mode_ctrl #(
    parameter int TW         = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_req,
    input  logic          soft_rst,
    input  logic          cmd_done,
    input  logic [TW-1:0] idle_limit,
    output logic [1:0]    mode,
    output logic          core_clk_en,
    output logic          wake_o
);
    import pm_pkg::*;

    pm_state_e state_q, state_d;
    logic      wake_q;
    logic      any_ev;
    logic      idle_run, idle_expired;
    logic      settle_run, settle_done;

    assign any_ev     = cmd_req | soft_rst;
    assign idle_run   = (state_q == PM_IDLE) && !any_ev;
    assign settle_run = (state_q == PM_WAKE);

    pm_idle_timer #(.TW(TW)) u_idle_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (idle_run),
        .limit   (idle_limit),
        .expired (idle_expired)
    );

    pm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_IDLE: begin
                if (any_ev) begin
                    state_d = PM_ACTIVE;      // start
                end else if (idle_expired) begin
                    state_d = PM_SLEEP;       // doze
                end
            end
            PM_ACTIVE: begin
                if (cmd_done && !any_ev) begin
                    state_d = PM_IDLE;        // finish
                end
            end
            PM_SLEEP: begin
                if (any_ev) begin
                    state_d = PM_WAKE;        // rouse
                end
            end
            PM_WAKE: begin
                if (settle_done) begin
                    state_d = PM_ACTIVE;      // settle
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_IDLE;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= (state_q == PM_WAKE) && settle_done;
        end
    end

    // Outputs
    always_comb begin
        mode        = state_q;
        core_clk_en = (state_q != PM_SLEEP);
        wake_o      = wake_q;
    end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int TW         = 16,
    parameter int SETTLE_CYC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_req,
    input logic          soft_rst,
    input logic          cmd_done,
    input logic [TW-1:0] idle_limit,
    input logic [1:0]    mode,
    input logic          core_clk_en,
    input logic          wake_o
);
    localparam logic [1:0] M_IDLE   = 2'd0;
    localparam logic [1:0] M_ACTIVE = 2'd1;
    localparam logic [1:0] M_SLEEP  = 2'd2;
    localparam logic [1:0] M_WAKE   = 2'd3;
    localparam int         RW       = $clog2(SETTLE_CYC + 2) + 1;

    logic          ev;
    logic [RW-1:0] wake_run;

    assign ev = cmd_req | soft_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_run <= '0;
        end else if (mode == M_WAKE) begin
            wake_run <= wake_run + 1'b1;
        end else begin
            wake_run <= '0;
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE && ev) |=> (mode == M_ACTIVE));

    assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ACTIVE && cmd_done && !ev) |=> (mode == M_IDLE));

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ACTIVE && ev) |=> (mode == M_ACTIVE));

    assert_no_doze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE && idle_limit == '0) |=> (mode != M_SLEEP));

    assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SLEEP) |-> !core_clk_en);

    assert_rouse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SLEEP && ev) |=> (mode == M_WAKE && core_clk_en));

    assert_settle_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WAKE) |-> (wake_run < RW'(SETTLE_CYC)));

    assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (mode == M_ACTIVE && $past(mode) == M_WAKE));

    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SLEEP && !ev) |=> (mode == M_SLEEP));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.TW(TW), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_req     (cmd_req),
    .soft_rst    (soft_rst),
    .cmd_done    (cmd_done),
    .idle_limit  (idle_limit),
    .mode        (mode),
    .core_clk_en (core_clk_en),
    .wake_o      (wake_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int TW = 8;
    localparam int SC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_req = 1'b0;
    logic          soft_rst = 1'b0;
    logic          cmd_done = 1'b0;
    logic [TW-1:0] idle_limit = 8'd6;
    logic [1:0]    mode;
    logic          core_clk_en;
    logic          wake_o;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    // Behavioural reference state
    int ms = 0;   // 0 idle, 1 active, 2 sleep, 3 wake
    int ic = 0;
    int sc = 0;
    int mw = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.TW(TW), .SETTLE_CYC(SC)) u_pwr_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_req     (cmd_req),
        .soft_rst    (soft_rst),
        .cmd_done    (cmd_done),
        .idle_limit  (idle_limit),
        .mode        (mode),
        .core_clk_en (core_clk_en),
        .wake_o      (wake_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0:       return "R4";
            1:       return "R3";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; ic = 0; sc = 0; mw = 0;
        end else begin
            int  nxt;
            bit  ev;
            ev  = cmd_req | soft_rst;
            nxt = ms;
            mw  = 0;
            case (ms)
                0: begin
                    if (ev) nxt = 1;
                    else if (idle_limit != 0 && ic + 1 >= int'(idle_limit)) nxt = 2;
                end
                1: begin
                    if (!ev && cmd_done) nxt = 0;
                end
                2: begin
                    if (ev) begin nxt = 3; sc = 0; end
                end
                default: begin
                    if (sc + 1 >= SC) begin nxt = 1; mw = 1; end
                    else sc = sc + 1;
                end
            endcase
            ic = (nxt == 0 && ms == 0 && !ev) ? ic + 1 : 0;
            ms = nxt;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({tag_of(ms), " mode"}, int'(mode), ms);
            chk("R6 clk_en", int'(core_clk_en), (ms != 2) ? 1 : 0);
            chk("R8 wake", int'(wake_o), mw);
        end
    end

    task automatic step(bit cr, bit sr, bit cd);
        cmd_req = cr; soft_rst = sr; cmd_done = cd;
        @(negedge clk);
        cmd_req = 1'b0; soft_rst = 1'b0; cmd_done = 1'b0;
    endtask

    task automatic go_sleep();
        step(1, 0, 0);
        step(0, 0, 1);
        for (int i = 0; i < int'(idle_limit); i++) step(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", int'(mode), 0);
        chk("R1 clk_en in reset", int'(core_clk_en), 1);
        rst_n = 1'b1;
        step(0, 0, 0);
        chk("R1 mode after release", int'(mode), 0);
        chk("R1 wake after release", int'(wake_o), 0);

        // start / finish / hold
        step(1, 0, 0);
        chk("R2 cmd_req to active", int'(mode), 1);
        step(0, 0, 0);
        chk("R3 active holds", int'(mode), 1);
        step(0, 0, 1);
        chk("R3 done to idle", int'(mode), 0);
        step(0, 1, 0);
        chk("R2 soft_rst to active", int'(mode), 1);
        step(1, 0, 1);
        chk("R3 done with new cmd stays active", int'(mode), 1);
        step(0, 0, 1);
        chk("R3 done to idle again", int'(mode), 0);

        // doze after exactly L idle cycles
        idle_limit = 8'd6;
        for (int i = 0; i < 5; i++) step(0, 0, 0);
        chk("R4 still idle at L-1", int'(mode), 0);
        step(0, 0, 0);
        chk("R4 sleep after L", int'(mode), 2);
        chk("R6 clk_en low in sleep", int'(core_clk_en), 0);
        step(0, 0, 1);
        chk("R9 done ignored in sleep", int'(mode), 2);

        // rouse and settle
        step(1, 0, 0);
        chk("R7 wake state", int'(mode), 3);
        chk("R7 clk_en in wake", int'(core_clk_en), 1);
        step(0, 0, 1);
        step(0, 1, 0);
        step(1, 0, 0);
        chk("R9 wake unaffected", int'(mode), 3);
        step(0, 0, 0);
        chk("R7 active after settle", int'(mode), 1);
        chk("R8 wake pulse", int'(wake_o), 1);
        step(0, 0, 0);
        chk("R8 wake pulse single", int'(wake_o), 0);

        // coincidence: event on the expiry cycle
        step(0, 0, 1);
        for (int i = 0; i < 5; i++) step(0, 0, 0);
        step(1, 0, 0);
        chk("R10 event beats timeout", int'(mode), 1);

        // zero threshold disables doze
        idle_limit = '0;
        step(0, 0, 1);
        for (int i = 0; i < 60; i++) step(0, 0, 0);
        chk("R5 zero limit stays idle", int'(mode), 0);

        // hardware reset from sleep and from wake
        idle_limit = 8'd3;
        go_sleep();
        chk("R4 sleep with L=3", int'(mode), 2);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset from sleep mode", int'(mode), 0);
        chk("R11 reset from sleep clk_en", int'(core_clk_en), 1);
        rst_n = 1'b1;
        step(0, 0, 0);
        go_sleep();
        step(0, 1, 0);
        chk("R7 soft_rst wakes", int'(mode), 3);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset from wake mode", int'(mode), 0);
        rst_n = 1'b1;
        step(0, 0, 0);
        chk("R11 idle after reset from wake", int'(mode), 0);

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) idle_limit = TW'($urandom % 7);
            if (n % 997 == 500) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
            end
            step(($urandom % 9) == 0, ($urandom % 17) == 0, ($urandom % 3) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule